// File: doc/BRIEF.md
# Cache Tag Store with Address Compare

This block holds the tags of a direct-mapped cache and answers, for each presented address, whether the cached line is the one being asked for. The address is split into two parts. The low `IDX_W` bits select one entry of the store. The upper `TAG_W` bits are compared against the word held in that entry. The default build has `IDX_W = 10`. Setting `IDX_W = 13` gives the full 8K x 8 organisation on a 21-bit address. The hit result leaves the block on an active-low line that either pulls low or floats. Because of this, the lines of several units can share one net with a pull-up and form a single hit signal with no gate between them.

One global clear empties every entry in a single clock cycle, so stale tags cannot produce false hits after power-up or a system reset. The same store can also act as a plain resettable RAM with a synchronous write port and a registered read port. Two units driven with the same index bits, each comparing its word against a different slice of a wider address, give a wider compare when their individual hits are combined.

Top module: `tag_cmp_ram`

## Requirements
- R1: With `sel` high, `wr` high and `wipe` low, `wdata` is stored at entry `addr[IDX_W-1:0]` on the clock edge, and a later selected access to that entry returns it.
- R2: `rdata` is driven in the cycle after a selected access when `rd_en` was high at that edge, and is released to high impedance otherwise.
- R3: `hit_n` is driven to 0 in the cycle after a selected access whose read word equals `addr[ADDR_W-1:IDX_W]`, and is released to high impedance otherwise.
- R4: With `sel` low the store does not change, even if `wr` is high, and `hit_n` is released in the following cycle.
- R5: A cycle with `wipe` high makes every entry read as 0x00 from the next edge on. A write in that same cycle is dropped.
- R6: After synchronous reset (`rst` high) every entry reads as 0x00, and both `hit_n` and `rdata` are released.
- R7: An entry never written since the last clear or reset reads as 0x00, so it compares equal to a tag of zero.
- R8: A selected write and read in the same cycle returns the entry's previous content. The new value is seen from the next access on.
- R9: A selected access in a cycle with `wipe` high returns 0x00.
- R10: When the `hit_n` lines of several units share one pulled-up net, the net is low if any selected unit hits and high if none does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | 1 | Unit select, gates access and compare |
| wr | input | 1 | Write enable |
| rd_en | input | 1 | Read data output enable |
| wipe | input | 1 | Clear all entries to zero |
| addr | input | ADDR_W | Index in low bits, compare tag in upper bits |
| wdata | input | TAG_W | Write data |
| rdata | output | TAG_W | Read data, high impedance when not enabled |
| hit_n | output | 1 | Active-low hit, driven 0 or released |

## Verification
Both the read word and the hit line change exactly one edge after the access that produced them, because each passes through one register. The bench applies inputs on the falling edge. On the next falling edge it compares the outputs with a model result computed from the inputs it has just replaced, and only then applies new inputs. The store contents seen by an access are taken from the model before that access's own write or clear is applied, so read-before-write and clear ordering are checked in the same cycle.

// File: rtl/tcr_pkg.sv
`timescale 1ns/1ps
package tcr_pkg;

    localparam int IDX_W_DEF = 10;
    localparam int TAG_W_DEF = 8;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_CLEAR = 2'd3
    } op_e;

    typedef struct packed {
        logic sel;
        logic oe;
    } rdctl_t;

    // Clear dominates; a write needs the unit selected.
    function automatic op_e decode_op(input logic sel, input logic wr, input logic wipe);
        if (wipe)
            return OP_CLEAR;
        else if (sel && wr)
            return OP_WRITE;
        else if (sel)
            return OP_READ;
        else
            return OP_IDLE;
    endfunction

endpackage

// File: rtl/tcr_store.sv
`timescale 1ns/1ps
module tcr_store
    import tcr_pkg::*;
#(
    parameter int IDX_W = IDX_W_DEF,
    parameter int TAG_W = TAG_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  op_e              op,
    input  logic [IDX_W-1:0] idx,
    input  logic [TAG_W-1:0] wdata,
    output logic [TAG_W-1:0] rd_word
);
    localparam int DEPTH = 1 << IDX_W;

    logic [TAG_W-1:0] mem [DEPTH];
    logic [DEPTH-1:0] valid;

    // Valid vector: wiped in one cycle, set per write.
    always_ff @(posedge clk) begin
        if (rst || op == OP_CLEAR)
            valid <= '0;
        else if (op == OP_WRITE)
            valid[idx] <= 1'b1;
    end

    // Data array has no reset; validity masks stale content.
    always_ff @(posedge clk) begin
        if (!rst && op == OP_WRITE)
            mem[idx] <= wdata;
    end

    // Registered read, old content on a same-cycle write.
    always_ff @(posedge clk) begin
        if (rst || op == OP_CLEAR)
            rd_word <= '0;
        else if (op == OP_READ || op == OP_WRITE)
            rd_word <= valid[idx] ? mem[idx] : '0;
    end

endmodule

// File: rtl/tcr_match.sv
`timescale 1ns/1ps
module tcr_match #(
    parameter int TAG_W = 8
) (
    input  logic [TAG_W-1:0] rd_word,
    input  logic [TAG_W-1:0] tag_q,
    input  logic             sel_q,
    output logic             match_drive,
    output logic             hit_n
);
    assign match_drive = sel_q && (rd_word == tag_q);
    // Open-drain style: pull low on hit, float otherwise.
    assign hit_n = match_drive ? 1'b0 : 1'bz;
endmodule

// File: rtl/tcr_outdrv.sv
`timescale 1ns/1ps
module tcr_outdrv #(
    parameter int TAG_W = 8
) (
    input  logic [TAG_W-1:0] rd_word,
    input  logic             sel_q,
    input  logic             oe_q,
    output logic             dout_drive,
    output logic [TAG_W-1:0] rdata
);
    assign dout_drive = sel_q && oe_q;
    assign rdata = dout_drive ? rd_word : {TAG_W{1'bz}};
endmodule

// File: rtl/tag_cmp_ram.sv
`timescale 1ns/1ps
module tag_cmp_ram
    import tcr_pkg::*;
#(
    parameter int IDX_W  = IDX_W_DEF,
    parameter int TAG_W  = TAG_W_DEF,
    parameter int ADDR_W = IDX_W + TAG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              wr,
    input  logic              rd_en,
    input  logic              wipe,
    input  logic [ADDR_W-1:0] addr,
    input  logic [TAG_W-1:0]  wdata,
    output logic [TAG_W-1:0]  rdata,
    output logic              hit_n
);
    op_e              op;
    logic [IDX_W-1:0] idx;
    logic [TAG_W-1:0] tag_in;
    logic [TAG_W-1:0] tag_q;
    logic [TAG_W-1:0] rd_word;
    rdctl_t           ctl_q;
    logic             match_drive;
    logic             dout_drive;

    assign op     = decode_op(sel, wr, wipe);
    assign idx    = addr[IDX_W-1:0];
    assign tag_in = addr[ADDR_W-1:IDX_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            tag_q <= '0;
        end else begin
            ctl_q.sel <= sel;
            ctl_q.oe  <= rd_en;
            if (sel)
                tag_q <= tag_in;
        end
    end

    tcr_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) store_i (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .idx     (idx),
        .wdata   (wdata),
        .rd_word (rd_word)
    );

    tcr_match #(.TAG_W(TAG_W)) match_i (
        .rd_word     (rd_word),
        .tag_q       (tag_q),
        .sel_q       (ctl_q.sel),
        .match_drive (match_drive),
        .hit_n       (hit_n)
    );

    tcr_outdrv #(.TAG_W(TAG_W)) outdrv_i (
        .rd_word    (rd_word),
        .sel_q      (ctl_q.sel),
        .oe_q       (ctl_q.oe),
        .dout_drive (dout_drive),
        .rdata      (rdata)
    );

endmodule

// File: rtl/tcr_checker.sv
`timescale 1ns/1ps
module tcr_checker #(
    parameter int IDX_W  = 10,
    parameter int TAG_W  = 8,
    parameter int ADDR_W = IDX_W + TAG_W
) (
    input logic              clk,
    input logic              rst,
    input logic              sel,
    input logic              wr,
    input logic              rd_en,
    input logic              wipe,
    input logic [ADDR_W-1:0] addr,
    input logic [TAG_W-1:0]  wdata,
    input logic [TAG_W-1:0]  rd_word,
    input logic              match_drive,
    input logic              dout_drive
);
    logic [1:0] pv;

    always_ff @(posedge clk) begin
        if (rst)
            pv <= 2'd0;
        else if (pv != 2'd2)
            pv <= pv + 2'd1;
    end

    a_r1_write_read_back: assert property (@(posedge clk) disable iff (rst)
        (pv == 2'd2 && $past(sel && wr && !wipe, 2) && $past(sel && !wr && !wipe)
         && $past(addr[IDX_W-1:0]) == $past(addr[IDX_W-1:0], 2))
        |-> rd_word == $past(wdata, 2));

    a_r2_data_released: assert property (@(posedge clk) disable iff (rst)
        (pv != 2'd0 && !($past(sel) && $past(rd_en))) |-> !dout_drive);

    a_r4_unselected_no_hit: assert property (@(posedge clk) disable iff (rst)
        (pv != 2'd0 && !$past(sel)) |-> !match_drive);

    a_r9_wipe_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (pv != 2'd0 && $past(wipe) && $past(sel)) |-> rd_word == '0);

    a_r5_wipe_nonzero_tag_misses: assert property (@(posedge clk) disable iff (rst)
        (pv != 2'd0 && $past(wipe) && $past(sel) && $past(addr[ADDR_W-1:IDX_W]) != '0)
        |-> !match_drive);

endmodule

bind tag_cmp_ram tcr_checker #(.IDX_W(IDX_W), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .sel         (sel),
    .wr          (wr),
    .rd_en       (rd_en),
    .wipe        (wipe),
    .addr        (addr),
    .wdata       (wdata),
    .rd_word     (rd_word),
    .match_drive (match_drive),
    .dout_drive  (dout_drive)
);

// File: tb/tag_cmp_ram_tb_top.sv
`timescale 1ns/1ps
module tag_cmp_ram_tb_top;
    localparam int IDX_W  = 10;
    localparam int TAG_W  = 8;
    localparam int ADDR_W = IDX_W + TAG_W;
    localparam int DEPTH  = 1 << IDX_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sel_a = 1'b0, sel_b = 1'b0, wr = 1'b0, rd_en = 1'b0, wipe = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [TAG_W-1:0]  wd_a = '0, wd_b = '0;

    wire             hit_bus;
    wire [TAG_W-1:0] dbus_a;
    wire [TAG_W-1:0] dbus_b;

    pullup pu_hit (hit_bus);
    for (genvar i = 0; i < TAG_W; i++) begin : g_pu
        pullup pu_a (dbus_a[i]);
        pullup pu_b (dbus_b[i]);
    end

    always #4 clk = ~clk;

    tag_cmp_ram #(.IDX_W(IDX_W), .TAG_W(TAG_W)) dut_i (
        .clk(clk), .rst(rst), .sel(sel_a), .wr(wr), .rd_en(rd_en), .wipe(wipe),
        .addr(addr), .wdata(wd_a), .rdata(dbus_a), .hit_n(hit_bus));

    tag_cmp_ram #(.IDX_W(IDX_W), .TAG_W(TAG_W)) dut_b (
        .clk(clk), .rst(rst), .sel(sel_b), .wr(wr), .rd_en(rd_en), .wipe(wipe),
        .addr(addr), .wdata(wd_b), .rdata(dbus_b), .hit_n(hit_bus));

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // Bench model
    logic [TAG_W-1:0] m_mem [2][DEPTH];
    bit               m_val [2][DEPTH];
    logic [TAG_W-1:0] m_rd  [2];
    logic [TAG_W-1:0] m_tag [2];
    bit               m_selq[2];
    bit               m_oeq;
    string            pend_req = "R6";

    function automatic logic exp_hit_n();
        bit any = 0;
        for (int u = 0; u < 2; u++)
            if (m_selq[u] && m_rd[u] == m_tag[u]) any = 1;
        return !any;
    endfunction

    function automatic logic [TAG_W-1:0] exp_dbus_a();
        return (m_selq[0] && m_oeq) ? m_rd[0] : {TAG_W{1'b1}};
    endfunction

    task automatic check_outputs();
        logic             eh = exp_hit_n();
        logic [TAG_W-1:0] ed = exp_dbus_a();
        n_chk++;
        if (hit_bus !== eh) begin
            n_bad++;
            $display("FAIL %s hit line: actual %b expected %b", pend_req, hit_bus, eh);
        end
        n_chk++;
        if (dbus_a !== ed) begin
            n_bad++;
            $display("FAIL %s read data: actual %h expected %h", pend_req, dbus_a, ed);
        end
    endtask

    task automatic model_reset();
        for (int u = 0; u < 2; u++) begin
            for (int i = 0; i < DEPTH; i++) m_val[u][i] = 0;
            m_rd[u] = '0; m_tag[u] = '0; m_selq[u] = 0;
        end
        m_oeq = 0;
    endtask

    // Check outputs of the previous step, then apply and model a new one.
    task automatic step(input bit sa, input bit sb, input bit w, input bit oe, input bit clr,
                        input logic [ADDR_W-1:0] a, input logic [TAG_W-1:0] da,
                        input logic [TAG_W-1:0] db, input string req);
        bit sl [2];
        logic [TAG_W-1:0] dv [2];
        logic [IDX_W-1:0] ix;
        @(negedge clk);
        check_outputs();
        sel_a = sa; sel_b = sb; wr = w; rd_en = oe; wipe = clr;
        addr = a; wd_a = da; wd_b = db;
        sl[0] = sa; sl[1] = sb; dv[0] = da; dv[1] = db;
        ix = a[IDX_W-1:0];
        for (int u = 0; u < 2; u++) begin
            if (clr) m_rd[u] = '0;
            else if (sl[u]) m_rd[u] = m_val[u][ix] ? m_mem[u][ix] : '0;
            if (sl[u]) m_tag[u] = a[ADDR_W-1:IDX_W];
            m_selq[u] = sl[u];
        end
        m_oeq = oe;
        for (int u = 0; u < 2; u++) begin
            if (clr) begin
                for (int i = 0; i < DEPTH; i++) m_val[u][i] = 0;
            end else if (sl[u] && w) begin
                m_mem[u][ix] = dv[u];
                m_val[u][ix] = 1;
            end
        end
        pend_req = req;
    endtask

    function automatic logic [ADDR_W-1:0] mk(input logic [TAG_W-1:0] t, input int i);
        return {t, i[IDX_W-1:0]};
    endfunction

    initial begin : main
        int unused_seed;
        unused_seed = $urandom(32'h1BADCAFE);
        model_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        pend_req = "R6";
        // R6: reset state, R7: unwritten entry reads zero and tag 0 hits
        step(1,0,0,1,0, mk(8'h00,5), 8'h00, 8'h00, "R6");
        step(1,0,0,1,0, mk(8'h00,5), 8'h00, 8'h00, "R7");
        // R1: write both units at entry 5
        step(1,1,1,0,0, mk(8'h00,5), 8'h3C, 8'h11, "R1");
        step(1,0,0,1,0, mk(8'h3C,5), 8'h00, 8'h00, "R1 R3");
        step(1,0,0,1,0, mk(8'h12,5), 8'h00, 8'h00, "R3");
        // R10: only unit B selected and hitting; R2: A's data released
        step(0,1,0,1,0, mk(8'h11,5), 8'h00, 8'h00, "R10 R2");
        step(1,1,0,1,0, mk(8'h11,5), 8'h00, 8'h00, "R10");
        step(1,1,0,1,0, mk(8'h77,5), 8'h00, 8'h00, "R10");
        // R4: unselected write dropped
        step(0,0,1,1,0, mk(8'h00,5), 8'h77, 8'h77, "R4");
        step(1,0,0,1,0, mk(8'h3C,5), 8'h00, 8'h00, "R4");
        // R8: write and read same cycle
        step(1,0,1,1,0, mk(8'h3C,5), 8'h55, 8'h00, "R8");
        step(1,0,0,1,0, mk(8'h55,5), 8'h00, 8'h00, "R8");
        // R5/R9: wipe with a write in the same cycle
        step(1,0,1,1,1, mk(8'h99,6), 8'h99, 8'h00, "R9");
        step(1,0,0,1,0, mk(8'h99,6), 8'h00, 8'h00, "R5");
        step(1,0,0,1,0, mk(8'h00,5), 8'h00, 8'h00, "R5");
        // R2: output enable low
        step(1,0,0,0,0, mk(8'h00,5), 8'h00, 8'h00, "R2");
        // Top index corner
        step(1,0,1,1,0, mk(8'h00,DEPTH-1), 8'hA5, 8'h00, "R1");
        step(1,0,0,1,0, mk(8'hA5,DEPTH-1), 8'h00, 8'h00, "R1 R3");
        // Random traffic on a narrow address window
        for (int k = 0; k < 3000; k++) begin
            bit sa = ($urandom % 4) != 0;
            bit sb = ($urandom % 3) == 0;
            bit w  = ($urandom % 3) == 0;
            bit oe = ($urandom % 4) != 0;
            bit cl = ($urandom % 97) == 0;
            int ix = ($urandom % 8 == 0) ? DEPTH - 1 : int'($urandom % 12);
            logic [TAG_W-1:0] t  = TAG_W'($urandom % 4);
            logic [TAG_W-1:0] da = TAG_W'($urandom % 4);
            logic [TAG_W-1:0] db = TAG_W'($urandom % 4);
            step(sa, sb, w, oe, cl, mk(t, ix), da, db, "R3 R10 random");
        end
        step(0,0,0,0,0, '0, '0, '0, "R4");
        // Reset mid-run: entries and outputs cleared
        @(negedge clk);
        check_outputs();
        rst = 1'b1; sel_a = 0; sel_b = 0; wr = 0; wipe = 0;
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        pend_req = "R6";
        step(1,0,0,1,0, mk(8'h00,5), 8'h00, 8'h00, "R6");
        step(0,0,0,0,0, '0, '0, '0, "R6");
        @(negedge clk);
        check_outputs();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule